// File: doc/BRIEF.md
# Dual-Compare Self-Reloading PWM Generator

This block produces a pulse-width modulated output by watching a free-running timer that it shares with other logic but never stops or resets. Two compare channels hold match times. When the timer lands on the first channel's match time the output goes high, and when it lands on the second channel's match time the output goes low. After each hit, and once a fixed service delay has passed, the block adds a programmed period constant to that channel's match time and stores the result back. The waveform therefore repeats with no further register writes.

The period comes from moving each match time forward by a constant, not from a counter that wraps at the period. The distance between the two match times sets the duty cycle, down to a pulse one timer count wide. A toggle mode uses only channel 0, which flips the output on every hit. In that mode the period constant is half the PWM period. A hit that arrives while that channel's previous reload is still waiting sets a sticky overrun flag.

Top module: `dual_cmp_pwm`

## Requirements
- R1: After reset the output is low, the overrun flag is clear, the block is disabled and both pending reloads are idle.
- R2: Register map on `wrAddr` with `wrEn` high: 0 is control (bit 0 enables, bit 8 selects paired mode), 1 is the period constant, 2 is the channel 0 match time and 3 is the channel 1 match time. A write to a match time cancels that channel's pending reload.
- R3: A hit is counted only on a cycle where the timer value differs from its value on the previous cycle and equals the channel's match time. A stalled timer never produces a repeated hit.
- R4: In paired mode a channel 0 hit drives the output high on the next cycle.
- R5: In paired mode a channel 1 hit drives the output low on the next cycle, and this wins over a channel 0 hit in the same cycle.
- R6: Exactly SVC_DLY cycles after a hit, that channel's match time becomes the old match time plus the period constant, modulo 2^TW.
- R7: Match times one count apart give a high pulse exactly one timer tick long in every period.
- R8: A new period constant is applied at the next reload that follows the write.
- R9: In toggle mode (bit 8 clear) each channel 0 hit inverts the output, and channel 1 has no effect.
- R10: While the block is disabled the output stays low and no hits or reloads happen.
- R11: A hit on a channel whose reload is still pending sets `overrun`, which stays set until the next control write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | TW | Write data |
| timer | input | TW | Shared free-running timer value |
| pwmOut | output | 1 | PWM output |
| overrun | output | 1 | Sticky flag for a hit while a reload is pending |

## Verification
The bench builds the block with TW=16 and SVC_DLY=3. With a three-cycle service delay, a timer that is driven by hand can return to a match value while the reload is still pending, so the overrun path can be reached. Because TW is 16, starting the timer and the match times near 0xFFF0 makes the reload sums wrap within a few hundred cycles. A timer that advances only every third clock exercises the tick-qualified match, where a level-based compare would fire more than once.

// File: rtl/dual_cmp_pwm_pkg.sv
package dual_cmp_pwm_pkg;
  typedef struct packed {
    logic [1:0] reload;
    logic       setOut;
    logic       clrOut;
    logic       tglOut;
  } pwmStb_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_TIME0  = 2'd2;
  localparam logic [1:0] ADDR_TIME1  = 2'd3;
  localparam int         EN_BIT      = 0;
  localparam int         PAIR_BIT    = 8;
endpackage

// File: rtl/pwm_dp.sv
module pwm_dp
  import dual_cmp_pwm_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [TW-1:0] wrData,
  input  logic [TW-1:0] timer,
  input  pwmStb_t       stb,
  output logic          en,
  output logic          pair,
  output logic          tick,
  output logic [1:0]    eq,
  output logic          wrCtrl,
  output logic [1:0]    wrTime,
  output logic          pwmOut
);
  logic [TW-1:0] periodReg;
  logic [TW-1:0] prevTimer;
  logic [TW-1:0] matchTime [2];
  logic          enReg, pairReg, pwmReg;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrTime[0] = wrEn && (wrAddr == ADDR_TIME0);
  assign wrTime[1] = wrEn && (wrAddr == ADDR_TIME1);
  assign tick = (timer != prevTimer);
  assign en = enReg;
  assign pair = pairReg;
  assign pwmOut = pwmReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg     <= 1'b0;
      pairReg   <= 1'b0;
      periodReg <= '0;
      prevTimer <= '0;
      pwmReg    <= 1'b0;
    end else begin
      prevTimer <= timer;
      if (wrCtrl) begin
        enReg   <= wrData[EN_BIT];
        pairReg <= wrData[PAIR_BIT];
      end
      if (wrEn && (wrAddr == ADDR_PERIOD)) periodReg <= wrData;
      if (!enReg)           pwmReg <= 1'b0;
      else if (stb.clrOut)  pwmReg <= 1'b0;
      else if (stb.setOut)  pwmReg <= 1'b1;
      else if (stb.tglOut)  pwmReg <= ~pwmReg;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign eq[ch] = (timer == matchTime[ch]);
    always_ff @(posedge clk) begin
      if (!rst_n)               matchTime[ch] <= '0;
      else if (wrTime[ch])      matchTime[ch] <= wrData;
      else if (stb.reload[ch])  matchTime[ch] <= matchTime[ch] + periodReg;
    end

    // R6: reload moves the match time forward by the period
    p_reload_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.reload[ch] && !wrTime[ch]) |=>
        (matchTime[ch] == $past(matchTime[ch] + periodReg)));
  end

  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enReg |=> !pwmReg);
  p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enReg && stb.setOut && !stb.clrOut) |=> pwmReg);
  p_clr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrOut |=> !pwmReg);
endmodule

// File: rtl/pwm_ctl.sv
module pwm_ctl
  import dual_cmp_pwm_pkg::*;
#(
  parameter int SVC_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pair,
  input  logic       tick,
  input  logic [1:0] eq,
  input  logic       wrCtrl,
  input  logic [1:0] wrTime,
  output pwmStb_t    stb,
  output logic       overrun
);
  localparam int CW = $clog2(SVC_DLY + 1);
  localparam logic [CW-1:0] DLY_LOAD = CW'(SVC_DLY);

  logic [1:0]    active, hit, lateHit;
  logic [CW-1:0] pendCnt [2];
  logic          ovrReg;

  assign active[0] = en;
  assign active[1] = en && pair;

  for (genvar ch = 0; ch < 2; ch++) begin : g_pend
    assign hit[ch] = active[ch] && tick && eq[ch];
    assign lateHit[ch] = hit[ch] && (pendCnt[ch] != '0);
    assign stb.reload[ch] = active[ch] && !wrTime[ch] && (pendCnt[ch] == CW'(1));
    always_ff @(posedge clk) begin
      if (!rst_n)                           pendCnt[ch] <= '0;
      else if (wrTime[ch] || !active[ch])   pendCnt[ch] <= '0;
      else if (hit[ch])                     pendCnt[ch] <= DLY_LOAD;
      else if (pendCnt[ch] != '0)           pendCnt[ch] <= pendCnt[ch] - CW'(1);
    end
  end

  assign stb.setOut = pair && hit[0];
  assign stb.clrOut = hit[1];
  assign stb.tglOut = !pair && hit[0];

  always_ff @(posedge clk) begin
    if (!rst_n)           ovrReg <= 1'b0;
    else if (wrCtrl)      ovrReg <= 1'b0;
    else if (|lateHit)    ovrReg <= 1'b1;
  end
  assign overrun = ovrReg;

  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovrReg && !wrCtrl) |=> ovrReg);
  p_ovr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrCtrl |=> !ovrReg);
endmodule

// File: rtl/dual_cmp_pwm.sv
module dual_cmp_pwm
  import dual_cmp_pwm_pkg::*;
#(
  parameter int TW      = 16,
  parameter int SVC_DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [TW-1:0] wrData,
  input  logic [TW-1:0] timer,
  output logic          pwmOut,
  output logic          overrun
);
  pwmStb_t    stb;
  logic       en, pair, tick, wrCtrl;
  logic [1:0] eq, wrTime;

  pwm_dp #(.TW(TW)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timer(timer), .stb(stb), .en(en), .pair(pair), .tick(tick), .eq(eq),
    .wrCtrl(wrCtrl), .wrTime(wrTime), .pwmOut(pwmOut)
  );

  pwm_ctl #(.SVC_DLY(SVC_DLY)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .pair(pair), .tick(tick), .eq(eq),
    .wrCtrl(wrCtrl), .wrTime(wrTime), .stb(stb), .overrun(overrun)
  );
endmodule

// File: tb/sim_dual_cmp_pwm.sv
module sim_dual_cmp_pwm;
  localparam int TW = 16;
  localparam int DLY = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = '0;
  logic [TW-1:0] wrData = '0;
  logic [TW-1:0] timer = 16'hFFE0;
  logic          pwmOut, overrun;

  int    total = 0, fails = 0;
  string curReq = "R1";
  int    tickDiv = 1, divCnt = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  dual_cmp_pwm #(.TW(TW), .SVC_DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timer(timer), .pwmOut(pwmOut), .overrun(overrun)
  );

  // behavioural reference
  int mEn, mPair, mPwm, mOvr, mPer, mPrev;
  int mTm[2];
  int mPend[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mPair = 0; mPwm = 0; mOvr = 0; mPer = 0; mPrev = 0;
      mTm[0] = 0; mTm[1] = 0; mPend[0] = 0; mPend[1] = 0;
    end else begin
      int t, h[2], act[2], nPwm, nTm[2];
      t = int'(timer);
      act[0] = mEn; act[1] = mEn & mPair;
      for (int c = 0; c < 2; c++)
        h[c] = (act[c] != 0 && t != mPrev && t == mTm[c]) ? 1 : 0;
      nPwm = mPwm;
      if (mEn == 0) nPwm = 0;
      else if (mPair != 0) begin
        if (h[1] != 0) nPwm = 0;
        else if (h[0] != 0) nPwm = 1;
      end else if (h[0] != 0) nPwm = 1 - mPwm;
      if (wrEn && wrAddr == 2'd0) mOvr = 0;
      else if ((h[0] != 0 && mPend[0] > 0) || (h[1] != 0 && mPend[1] > 0)) mOvr = 1;
      for (int c = 0; c < 2; c++) begin
        bit wt;
        wt = wrEn && (wrAddr == 2'(c + 2));
        nTm[c] = mTm[c];
        if (wt) nTm[c] = int'(wrData);
        else if (act[c] != 0 && mPend[c] == 1) nTm[c] = (mTm[c] + mPer) % 65536;
        if (wt || act[c] == 0) mPend[c] = 0;
        else if (h[c] != 0) mPend[c] = DLY;
        else if (mPend[c] > 0) mPend[c] = mPend[c] - 1;
        mTm[c] = nTm[c];
      end
      mPwm = nPwm;
      if (wrEn && wrAddr == 2'd0) begin mEn = int'(wrData[0]); mPair = int'(wrData[8]); end
      if (wrEn && wrAddr == 2'd1) mPer = int'(wrData);
      mPrev = t;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(pwmOut) == mPwm, curReq, "pwmOut vs model", int'(pwmOut), mPwm);
      check(int'(overrun) == mOvr, curReq, "overrun vs model", int'(overrun), mOvr);
    end
  end

  task automatic step(input bit doWr = 1'b0, input logic [1:0] a = '0, input int d = 0);
    @(negedge clk);
    wrEn = doWr; wrAddr = a; wrData = TW'(d);
    divCnt++;
    if (divCnt >= tickDiv) begin divCnt = 0; timer = timer + 1'b1; end
  endtask

  task automatic stepT(input int v);
    @(negedge clk);
    wrEn = 1'b0; timer = TW'(v);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic countHigh(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step();
      #1 if (pwmOut) cnt++;
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    int cnt, base;
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1", "pwmOut in reset", int'(pwmOut), 0);
    check(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    curReq = "R1";
    run(3);

    // R2 R4 R5 R6: paired mode across timer wrap
    curReq = "R4";
    base = int'(timer);
    step(1, 2'd1, 20);
    step(1, 2'd2, (base + 10) % 65536);
    step(1, 2'd3, (base + 17) % 65536);
    step(1, 2'd0, 16'h0101);
    curReq = "R6";
    countHigh(80, cnt);
    check(cnt == 28, "R5", "high cycles over 4 periods", cnt, 28);

    // R8: period change applies at next reload
    curReq = "R8";
    step(1, 2'd1, 30);
    run(120);

    // R7: one-count pulse
    curReq = "R7";
    step(1, 2'd0, 0);
    base = int'(timer);
    step(1, 2'd1, 16);
    step(1, 2'd2, (base + 6) % 65536);
    step(1, 2'd3, (base + 7) % 65536);
    step(1, 2'd0, 16'h0101);
    run(10);
    countHigh(48, cnt);
    check(cnt == 3, "R7", "one-tick pulses in 48 cycles", cnt, 3);

    // R3: stalled timer, one tick every three cycles
    curReq = "R3";
    tickDiv = 3;
    run(9);
    countHigh(96, cnt);
    check(cnt == 6, "R3", "high cycles with slow timer", cnt, 6);
    check(overrun == 1'b0, "R3", "no overrun on stalled timer", int'(overrun), 0);
    tickDiv = 1;

    // R2: rewriting a match time mid-run cancels its pending reload
    curReq = "R2";
    base = int'(timer);
    step(1, 2'd2, (base + 3) % 65536);
    run(40);

    // R9: toggle mode, channel 1 ignored
    curReq = "R9";
    step(1, 2'd0, 0);
    base = int'(timer);
    step(1, 2'd1, 8);
    step(1, 2'd2, (base + 6) % 65536);
    step(1, 2'd3, (base + 9) % 65536);
    step(1, 2'd0, 16'h0001);
    run(6);
    countHigh(32, cnt);
    check(cnt == 16, "R9", "toggle duty over 4 toggles", cnt, 16);

    // R10: disabled block stays low
    curReq = "R10";
    step(1, 2'd0, 0);
    base = int'(timer);
    step(1, 2'd2, (base + 4) % 65536);
    step(1, 2'd3, (base + 6) % 65536);
    countHigh(30, cnt);
    check(cnt == 0, "R10", "high cycles while disabled", cnt, 0);

    // R11: hit while pending sets sticky overrun; control write clears
    curReq = "R11";
    step(1, 2'd1, 0);
    step(1, 2'd2, 16'h4000);
    step(1, 2'd3, 16'h9000);
    step(1, 2'd0, 16'h0101);
    stepT(16'h3FFF);
    stepT(16'h4000);
    stepT(16'h4001);
    stepT(16'h4000);
    stepT(16'h4001);
    #1 check(overrun == 1'b1, "R11", "overrun after late hit", int'(overrun), 1);
    stepT(16'h4002);
    stepT(16'h4003);
    #1 check(overrun == 1'b1, "R11", "overrun sticky", int'(overrun), 1);
    step(1, 2'd0, 16'h0101);
    step();
    #1 check(overrun == 1'b0, "R11", "overrun cleared by control write", int'(overrun), 0);
    run(5);
    finishRun();
  end
endmodule